// File: doc/BRIEF.md
# PCI Bus Request and Parking Controller

This block is the master-side control for one PCI bus interface. It raises the request line when a transaction is waiting. It parks the bus while the agent holds grant but has no work, and releases the lines when grant goes away. It also decides the clock in which the transaction engine may assert FRAME#. Data generation, parity of real transfers and the transaction state machine sit elsewhere. This block provides only the output enables, the fixed park pattern with its parity, and a one-cycle FRAME# strobe.

Two arbitration modes exist. With the internal arbiter, grant comes in on the normal grant pin, and a parked agent may start a transaction on the next clock. With an external arbiter, grant comes in on a repurposed input pin and the normal grant pin is ignored. In that mode a transaction always starts one cycle after grant is seen in answer to the agent's own request.

Top module: `pci_park_ctrl`

## Requirements
- R1: During reset, req_n and frame_n are 1 and ad_oe and par_oe are 0.
- R2: req_n goes to 0 at the first clock edge that samples pend high, unless a start fires at that edge. req_n returns to 1 at the edge where the start fires.
- R3: ad_oe becomes 1 after an edge where grant is asserted, idle is high, req_n is 1 and no start fires. It becomes 0 after an edge where idle is low.
- R4: par_oe becomes 1 exactly one clock after ad_oe does, and par_oe is never 1 while ad_oe is 0.
- R5: After any edge that samples grant deasserted, ad_oe and par_oe are both 0.
- R6: park_ad and park_cbe carry the parameter constants PARK_AD and PARK_CBE. park_par is 1 when the count of ones in {park_ad, park_cbe} is odd, so that the total over all three is even.
- R7: Internal mode (ext_arb = 0): if ad_oe is 1 and the edge samples pend = 1, idle = 1 and grant asserted, frame_n is 0 after that edge. The same edge drops ad_oe and par_oe.
- R8: Internal mode: if one edge samples grant asserted while req_n is 0, then the next edge starts the transaction if it samples pend = 1, idle = 1 and grant asserted.
- R9: Grant is gnt_n = 0 when ext_arb = 0 and ext_gnt_n = 0 when ext_arb = 1. The unselected pin has no effect.
- R10: External mode: a start fires only at the edge after an edge that sampled ext_gnt_n = 0 with req_n = 0. Pend held without that grant never starts, and a parked agent asserts req_n first.
- R11: frame_n is 0 for exactly one cycle per start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_arb | input | 1 | 1 selects external-arbiter mode |
| gnt_n | input | 1 | Bus grant from the internal arbiter, active low |
| ext_gnt_n | input | 1 | Repurposed pin carrying the external grant, active low |
| pend | input | 1 | A transaction is waiting to start |
| idle | input | 1 | Bus is idle |
| req_n | output | 1 | Bus request, active low |
| frame_n | output | 1 | One-cycle FRAME# start strobe, active low |
| ad_oe | output | 1 | Output enable for AD and C/BE |
| par_oe | output | 1 | Output enable for PAR |
| park_ad | output | AD_W | Value driven on AD while parked |
| park_cbe | output | CBE_W | Value driven on C/BE while parked |
| park_par | output | 1 | Even parity for the park value |

## Verification
The properties assume that pend stays high until the start strobe appears and is dropped in the cycle that follows it. They also assume ext_arb changes only while both output enables are off, and that every input comes from the PCI clock domain. The stimulus changes inputs one time unit after the falling edge. It lowers pend in the cycle after frame_n is seen low, and it switches modes only after grant has been deasserted and the lines have been released.

// File: rtl/pci_park_pkg.sv
package pci_park_pkg;

  typedef enum logic {
    ARB_INTERNAL = 1'b0,
    ARB_EXTERNAL = 1'b1
  } arb_mode_e;

  // Even parity: PAR makes the total count of ones over value and PAR even.
  function automatic logic even_par(input logic [63:0] v);
    return ^v;
  endfunction

endpackage

// File: rtl/pci_grant_sel.sv
module pci_grant_sel
  import pci_park_pkg::*;
(
  input  logic ext_arb,
  input  logic gnt_n,
  input  logic ext_gnt_n,
  output logic grant
);
  arb_mode_e mode;

  always_comb begin
    mode  = arb_mode_e'(ext_arb);
    grant = (mode == ARB_EXTERNAL) ? ~ext_gnt_n : ~gnt_n;
  end
endmodule

// File: rtl/pci_req_ctrl.sv
module pci_req_ctrl
  import pci_park_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ext_arb,
  input  logic grant,
  input  logic pend,
  input  logic idle,
  input  logic parked,
  output logic req_q,
  output logic gseen_q,
  output logic fire,
  output logic frame_q
);
  arb_mode_e mode;
  logic      fire_int;
  logic      fire_ext;

  always_comb begin
    mode     = arb_mode_e'(ext_arb);
    // internal arbiter: start from park, or after a granted request
    fire_int = pend & idle & grant & (parked | gseen_q);
    // external arbiter: one cycle after grant seen against our request
    fire_ext = pend & idle & gseen_q;
    fire     = (mode == ARB_EXTERNAL) ? fire_ext : fire_int;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      gseen_q <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      req_q   <= pend & ~fire;
      gseen_q <= grant & req_q & ~fire;
      frame_q <= fire;
    end
  end
endmodule

// File: rtl/pci_park_drive.sv
module pci_park_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic idle,
  input  logic req_q,
  input  logic fire,
  output logic ad_oe_q,
  output logic par_oe_q
);
  logic park_ok;

  always_comb park_ok = grant & idle & ~req_q & ~fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ad_oe_q  <= 1'b0;
      par_oe_q <= 1'b0;
    end else begin
      ad_oe_q  <= park_ok;
      par_oe_q <= park_ok & ad_oe_q;
    end
  end
endmodule

// File: rtl/pci_park_ctrl.sv
module pci_park_ctrl
  import pci_park_pkg::*;
#(
  parameter int            AD_W     = 32,
  parameter int            CBE_W    = 4,
  parameter logic [AD_W-1:0]  PARK_AD  = 32'h0000_0001,
  parameter logic [CBE_W-1:0] PARK_CBE = 4'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_arb,
  input  logic             gnt_n,
  input  logic             ext_gnt_n,
  input  logic             pend,
  input  logic             idle,
  output logic             req_n,
  output logic             frame_n,
  output logic             ad_oe,
  output logic             par_oe,
  output logic [AD_W-1:0]  park_ad,
  output logic [CBE_W-1:0] park_cbe,
  output logic             park_par
);
  localparam int BUS_W = AD_W + CBE_W;

  logic grant;
  logic req_q;
  logic gseen_q;
  logic fire;
  logic frame_q;
  logic ad_oe_q;
  logic par_oe_q;
  logic [BUS_W-1:0] park_bus;

  pci_grant_sel u_gsel (
    .ext_arb   (ext_arb),
    .gnt_n     (gnt_n),
    .ext_gnt_n (ext_gnt_n),
    .grant     (grant)
  );

  pci_req_ctrl u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_arb (ext_arb),
    .grant   (grant),
    .pend    (pend),
    .idle    (idle),
    .parked  (ad_oe_q),
    .req_q   (req_q),
    .gseen_q (gseen_q),
    .fire    (fire),
    .frame_q (frame_q)
  );

  pci_park_drive u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .idle     (idle),
    .req_q    (req_q),
    .fire     (fire),
    .ad_oe_q  (ad_oe_q),
    .par_oe_q (par_oe_q)
  );

  always_comb begin
    park_bus = {PARK_AD, PARK_CBE};
    req_n    = ~req_q;
    frame_n  = ~frame_q;
    ad_oe    = ad_oe_q;
    par_oe   = par_oe_q;
    park_ad  = PARK_AD;
    park_cbe = PARK_CBE;
    park_par = even_par(64'(park_bus));
  end
endmodule

// File: rtl/pci_park_ctrl_chk.sv
module pci_park_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic grant,
  input logic pend,
  input logic idle,
  input logic req_n,
  input logic frame_n,
  input logic ad_oe,
  input logic par_oe
);
  p_par_needs_ad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> ad_oe);

  p_par_lags_ad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_oe) |-> $past(ad_oe));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> (!ad_oe && !par_oe));

  p_park_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> ($past(grant) && $past(idle) && $past(req_n)));

  p_frame_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> frame_n);

  p_start_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> ($past(pend) && $past(idle)));

  p_req_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> req_n);
endmodule

bind pci_park_ctrl pci_park_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .grant   (grant),
  .pend    (pend),
  .idle    (idle),
  .req_n   (req_n),
  .frame_n (frame_n),
  .ad_oe   (ad_oe),
  .par_oe  (par_oe)
);

// File: tb/test_pci_park_ctrl.sv
module test_pci_park_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_arb = 1'b0, gnt_n = 1'b1, ext_gnt_n = 1'b1, pend = 1'b0, idle = 1'b1;
  logic req_n, frame_n, ad_oe, par_oe, park_par;
  logic [31:0] park_ad;
  logic [3:0]  park_cbe;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    int    cyc;
    logic  req_n, frame_n, ad_oe, par_oe;
    string tag;
  } exp_t;
  exp_t sb[$];

  pci_park_ctrl i_pci_park_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_arb(ext_arb), .gnt_n(gnt_n),
    .ext_gnt_n(ext_gnt_n), .pend(pend), .idle(idle), .req_n(req_n),
    .frame_n(frame_n), .ad_oe(ad_oe), .par_oe(par_oe), .park_ad(park_ad),
    .park_cbe(park_cbe), .park_par(park_par)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: {req_n,frame_n,ad_oe,par_oe} actual %b expected %b", tag, act, expv);
    end
  endtask

  // monitor: pops expectations due in this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, {req_n, frame_n, ad_oe, par_oe}, {e.req_n, e.frame_n, e.ad_oe, e.par_oe});
    end
  end

  // driver: apply one cycle of inputs and queue the outputs expected after the edge
  task automatic tick(input logic x, input logic g, input logic eg, input logic p,
                      input logic i, input logic er, input logic ef, input logic ea,
                      input logic ep, input string tag);
    exp_t e;
    @(negedge clk); #1;
    ext_arb = x; gnt_n = g; ext_gnt_n = eg; pend = p; idle = i;
    e.cyc = cyc + 1; e.req_n = er; e.frame_n = ef; e.ad_oe = ea; e.par_oe = ep; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk("R1 reset state", {req_n, frame_n, ad_oe, par_oe}, 4'b1100);
    #1 rst_n = 1'b1;

    begin : park_values_r6
      int ones = 0;
      for (int k = 0; k < 32; k++) ones += int'(park_ad[k]);
      for (int k = 0; k < 4; k++)  ones += int'(park_cbe[k]);
      chk("R6 park value", {park_ad == 32'h1, park_cbe == 4'h0, park_par, 1'b0},
          {1'b1, 1'b1, logic'(ones % 2 == 1), 1'b0});
    end

    // internal mode: park, then start straight from park
    tick(0,0,1,0,1, 1,1,1,0, "R3 park on grant");
    tick(0,0,1,0,1, 1,1,1,1, "R4 PAR one clock later");
    tick(0,0,1,1,1, 1,0,0,0, "R7 start from park");
    tick(0,0,1,0,1, 1,1,1,0, "R11 single strobe, re-park");
    tick(0,0,1,0,1, 1,1,1,1, "R4 PAR follows again");
    tick(0,1,1,0,1, 1,1,0,0, "R5 release on grant loss");
    // internal mode: request, then grant
    tick(0,1,1,1,1, 0,1,0,0, "R2 request asserted");
    tick(0,1,1,1,1, 0,1,0,0, "R2 request held");
    tick(0,0,1,1,1, 0,1,0,0, "R8 grant seen, no park");
    tick(0,0,1,1,1, 1,0,0,0, "R8 start after grant");
    tick(0,0,1,0,1, 1,1,1,0, "R11 strobe ends");
    tick(0,0,1,0,1, 1,1,1,1, "R4 parked");
    tick(0,0,1,0,0, 1,1,0,0, "R3 busy bus unparks");
    tick(0,1,1,0,1, 1,1,0,0, "R5 released");
    // external mode: normal grant pin asserted but ignored
    tick(1,0,1,0,1, 1,1,0,0, "R9 gnt_n ignored");
    tick(1,0,0,0,1, 1,1,1,0, "R9 ext grant parks");
    tick(1,0,0,0,1, 1,1,1,1, "R4 ext PAR later");
    tick(1,0,0,1,1, 0,1,1,1, "R10 request from park");
    tick(1,0,0,1,1, 0,1,0,0, "R10 grant seen");
    tick(1,0,0,1,1, 1,0,0,0, "R10 start one cycle later");
    tick(1,0,0,0,1, 1,1,1,0, "R11 ext strobe ends");
    tick(1,0,1,0,1, 1,1,0,0, "R5 ext release");
    tick(1,0,1,1,1, 0,1,0,0, "R10 request no grant");
    tick(1,0,1,1,1, 0,1,0,0, "R10 no start without grant");
    tick(1,0,0,1,1, 0,1,0,0, "R10 grant seen late");
    tick(1,0,0,1,1, 1,0,0,0, "R10 late start");
    tick(1,0,1,0,1, 1,1,0,0, "R11 done");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule